// File: doc/BRIEF.md
# Split Data/MAC Authentication Buffer

This block sits on the receive side of a snooping bus on which each encrypted data block and its message authentication code (MAC) travel as two separate transactions. The data transaction comes first and carries an id; the MAC transaction with the same id follows later. Other data transactions may arrive in between, so MACs can arrive in any order relative to the data they cover. On each accepted data transaction the buffer claims a free entry and returns that entry's tag to the consumer. The entry is then pending, and the consumer may use the value speculatively.

When a MAC transaction arrives, the buffer looks up the pending entry with the same id. It compares the received MAC with the locally computed one, which arrives on an input. On a match the entry becomes verified. On a mismatch it becomes violated and an integrity violation is reported. A MAC that finds no pending entry is reported as an orphan.

Downstream logic asks through a mask-based query whether every tag that a result depends on is verified. It uses the answer to hold back a store to memory, or an instruction fetch whose address came from unverified data. The consumer releases a tag once that tag is resolved, which returns the entry to the free pool.

Top module: `split_auth_buffer`

## Requirements
- R1: After reset every entry is free: `data_ready` is 1, `alloc_valid`, `viol_valid`, `orphan_err` and `query_ok` are 0.
- R2: A data transaction accepted in cycle t (`data_valid` and `data_ready`) takes the lowest-numbered free entry; `alloc_valid` is 1 and `alloc_tag` holds that entry index in cycle t+1, and `alloc_valid` is 0 in cycles with no acceptance.
- R3: `data_ready` is 0 while all entries are in use; a data transaction offered then is not accepted and produces no allocation.
- R4: A MAC transaction whose id matches a pending entry and whose received MAC equals the computed MAC makes that entry verified, whatever order MACs arrive in relative to other data.
- R5: If the matched MAC differs from the computed one, `viol_valid` is 1 with `viol_tag` equal to the entry index in the next cycle, and that entry never becomes verified.
- R6: A MAC transaction whose id matches no pending entry (free, verified or violated entries do not count) raises `orphan_err` in the next cycle and changes no entry.
- R7: If several pending entries hold the same id, a MAC resolves the lowest-numbered one.
- R8: `query_ok` in cycle t+1 is 1 exactly when every entry whose bit is set in the `query_mask` of cycle t (bit i stands for tag i) is verified; an all-zero mask gives 1.
- R9: Releasing a verified or violated tag frees the entry; releasing a pending or free tag has no effect.
- R10: An entry released in cycle t cannot be allocated in cycle t, and data accepted in cycle t cannot be matched by a MAC presented in the same cycle t (that MAC is an orphan).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_valid | input | 1 | Data transaction present |
| data_id | input | ID_W | Transaction id of the data |
| data_ready | output | 1 | A free entry exists; low means backpressure |
| alloc_valid | output | 1 | An entry was allocated last cycle |
| alloc_tag | output | TAG_W | Tag of the allocated entry |
| mac_valid | input | 1 | MAC transaction present |
| mac_id | input | ID_W | Transaction id of the MAC |
| mac_rx | input | MAC_W | MAC received from the bus |
| mac_calc | input | MAC_W | MAC computed locally for that data |
| viol_valid | output | 1 | Integrity violation pulse |
| viol_tag | output | TAG_W | Tag of the violated entry |
| orphan_err | output | 1 | MAC with no pending entry pulse |
| release_valid | input | 1 | Consumer releases a tag |
| release_tag | input | TAG_W | Tag being released |
| query_mask | input | ENTRIES | Tags that a commit depends on |
| query_ok | output | 1 | All queried tags verified |

## Verification
The bench goes after MACs that arrive out of order and interleaved with newer data. A design that matched by arrival order would verify the wrong entry or miss the violation. Duplicate pending ids and MACs arriving after their entry was already resolved are both exercised. A design that re-matched a resolved entry would turn a violated entry verified instead of reporting an orphan. Release of still-pending tags and same-cycle release/allocate and data/MAC collisions are exercised, so that early reuse of an entry or early matching shows up at `alloc_tag` and `orphan_err`. After each phase the query is swept over every mask against the expected per-tag status. A design that ignored masked bits or unverified entries would open the commit gate early.

// File: rtl/sab_pkg.sv
package sab_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_GOOD = 2'd2,
    ST_BAD  = 2'd3
  } ent_state_t;
endpackage

// File: rtl/sab_prio_enc.sv
module sab_prio_enc #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/sab_id_cam.sv
module sab_id_cam #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [ID_W-1:0]  key,
  input  logic [DEPTH-1:0] elig,
  output logic [DEPTH-1:0] hit
);
  logic [ID_W-1:0] id_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) id_mem[wr_idx] <= wr_id;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = elig[g] && (id_mem[g] == key);
  end
endmodule

// File: rtl/split_auth_buffer.sv
module split_auth_buffer
  import sab_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 8,
  parameter int MAC_W   = 32,
  localparam int TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               data_valid,
  input  logic [ID_W-1:0]    data_id,
  output logic               data_ready,
  output logic               alloc_valid,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic               mac_valid,
  input  logic [ID_W-1:0]    mac_id,
  input  logic [MAC_W-1:0]   mac_rx,
  input  logic [MAC_W-1:0]   mac_calc,
  output logic               viol_valid,
  output logic [TAG_W-1:0]   viol_tag,
  output logic               orphan_err,
  input  logic               release_valid,
  input  logic [TAG_W-1:0]   release_tag,
  input  logic [ENTRIES-1:0] query_mask,
  output logic               query_ok
);
  ent_state_t st_q [ENTRIES];

  logic [ENTRIES-1:0] free_vec, pend_vec, good_vec, hit_vec;
  logic               free_any, hit_any, take, mac_ok;
  logic [TAG_W-1:0]   free_idx, hit_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
    assign free_vec[g] = (st_q[g] == ST_FREE);
    assign pend_vec[g] = (st_q[g] == ST_PEND);
    assign good_vec[g] = (st_q[g] == ST_GOOD);
  end

  assign data_ready = free_any;
  assign take       = data_valid && free_any;
  assign mac_ok     = (mac_rx == mac_calc);

  sab_prio_enc #(.N(ENTRIES)) u_free_pick (
    .req(free_vec), .any(free_any), .idx(free_idx)
  );

  sab_id_cam #(.DEPTH(ENTRIES), .ID_W(ID_W)) u_cam (
    .clk(clk), .wr_en(take), .wr_idx(free_idx), .wr_id(data_id),
    .key(mac_id), .elig(pend_vec), .hit(hit_vec)
  );

  sab_prio_enc #(.N(ENTRIES)) u_hit_pick (
    .req(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= ST_FREE;
      alloc_valid <= 1'b0;
      alloc_tag   <= '0;
      viol_valid  <= 1'b0;
      viol_tag    <= '0;
      orphan_err  <= 1'b0;
      query_ok    <= 1'b0;
    end else begin
      alloc_valid <= take;
      if (take) alloc_tag <= free_idx;
      viol_valid  <= mac_valid && hit_any && !mac_ok;
      if (mac_valid && hit_any) viol_tag <= hit_idx;
      orphan_err  <= mac_valid && !hit_any;
      query_ok    <= &(~query_mask | good_vec);
      for (int i = 0; i < ENTRIES; i++) begin
        case (st_q[i])
          ST_FREE: if (take && free_idx == TAG_W'(i)) st_q[i] <= ST_PEND;
          ST_PEND: if (mac_valid && hit_any && hit_idx == TAG_W'(i))
                     st_q[i] <= mac_ok ? ST_GOOD : ST_BAD;
          default: if (release_valid && release_tag == TAG_W'(i)) st_q[i] <= ST_FREE;
        endcase
      end
    end
  end

  assert_no_alloc_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !data_ready) |=> !alloc_valid);

  assert_orphan_needs_mac_R6: assert property (@(posedge clk) disable iff (rst)
    orphan_err |-> $past(mac_valid));

  assert_viol_marks_bad_R5: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> (st_q[viol_tag] == ST_BAD));

  assert_alloc_is_pending_R2: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> pend_vec[alloc_tag]);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    assert_verify_needs_mac_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(good_vec[g]) |-> $past(mac_valid));
    assert_retire_when_done_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(free_vec[g]) |-> $past(st_q[g] == ST_GOOD || st_q[g] == ST_BAD));
  end
endmodule

// File: tb/sim_split_auth_buffer.sv
module sim_split_auth_buffer;
  localparam int ENTRIES = 4;
  localparam int ID_W    = 6;
  localparam int MAC_W   = 16;
  localparam int TAG_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_valid = 1'b0;
  logic [ID_W-1:0] data_id = '0;
  logic data_ready, alloc_valid, viol_valid, orphan_err, query_ok;
  logic [TAG_W-1:0] alloc_tag, viol_tag;
  logic mac_valid = 1'b0;
  logic [ID_W-1:0] mac_id = '0;
  logic [MAC_W-1:0] mac_rx = '0, mac_calc = '0;
  logic release_valid = 1'b0;
  logic [TAG_W-1:0] release_tag = '0;
  logic [ENTRIES-1:0] query_mask = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mst [ENTRIES];  // 0 free, 1 pending, 2 verified, 3 violated
  int mid [ENTRIES];

  always #2 clk = ~clk;

  split_auth_buffer #(.ENTRIES(ENTRIES), .ID_W(ID_W), .MAC_W(MAC_W)) u0 (
    .clk(clk), .rst(rst), .data_valid(data_valid), .data_id(data_id),
    .data_ready(data_ready), .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
    .mac_valid(mac_valid), .mac_id(mac_id), .mac_rx(mac_rx), .mac_calc(mac_calc),
    .viol_valid(viol_valid), .viol_tag(viol_tag), .orphan_err(orphan_err),
    .release_valid(release_valid), .release_tag(release_tag),
    .query_mask(query_mask), .query_ok(query_ok)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < ENTRIES; i++) if (mst[i] == 0) return i;
    return -1;
  endfunction

  function automatic int any_free();
    return (lowest_free() >= 0) ? 1 : 0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    data_valid = 0; mac_valid = 0; release_valid = 0; query_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin mst[i] = 0; mid[i] = 0; end
  endtask

  task automatic send_data(int id);
    int t;
    t = lowest_free();
    chk("R3 data_ready", data_ready, (t >= 0) ? 1 : 0);
    data_valid = 1; data_id = ID_W'(id);
    @(negedge clk);
    data_valid = 0;
    if (t >= 0) begin
      chk("R2 alloc_valid", alloc_valid, 1);
      chk("R2 alloc_tag", alloc_tag, t);
      mst[t] = 1; mid[t] = id;
    end else begin
      chk("R3 no alloc when full", alloc_valid, 0);
    end
  endtask

  task automatic send_mac(int id, int rx, int calc);
    int t;
    t = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (mst[i] == 1 && mid[i] == id) t = i;
    mac_valid = 1; mac_id = ID_W'(id); mac_rx = MAC_W'(rx); mac_calc = MAC_W'(calc);
    @(negedge clk);
    mac_valid = 0;
    if (t >= 0) begin
      chk("R6 no orphan on match", orphan_err, 0);
      chk("R5 viol_valid", viol_valid, (rx != calc) ? 1 : 0);
      if (rx != calc) chk("R5 viol_tag / R7 lowest match", viol_tag, t);
      mst[t] = (rx == calc) ? 2 : 3;
    end else begin
      chk("R6 orphan_err", orphan_err, 1);
      chk("R6 no viol on orphan", viol_valid, 0);
    end
  endtask

  task automatic rel(int tag);
    release_valid = 1; release_tag = TAG_W'(tag);
    @(negedge clk);
    release_valid = 0;
    if (mst[tag] >= 2) mst[tag] = 0;
    chk("R9 data_ready after release", data_ready, any_free());
  endtask

  task automatic q_sweep();
    for (int m = 0; m < (1 << ENTRIES); m++) begin
      int exp;
      exp = 1;
      for (int i = 0; i < ENTRIES; i++) if (m[i] && mst[i] != 2) exp = 0;
      query_mask = ENTRIES'(m);
      @(negedge clk);
      chk("R8 query_ok", query_ok, exp);
    end
    query_mask = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 data_ready", data_ready, 1);
    chk("R1 alloc_valid", alloc_valid, 0);
    chk("R1 viol_valid", viol_valid, 0);
    chk("R1 orphan_err", orphan_err, 0);
    chk("R1 query_ok", query_ok, 0);
    q_sweep();

    // fill, then offer data while full
    send_data(10); send_data(11); send_data(12); send_data(13);
    send_data(14);
    chk("R3 still full", data_ready, 0);

    // out-of-order MACs
    send_mac(12, 16'h1111, 16'h1111);   // R4
    send_mac(10, 16'h2222, 16'h2222);   // R4
    send_mac(13, 16'h3333, 16'h3334);   // R5
    q_sweep();
    send_mac(13, 16'h3333, 16'h3333);   // R6 entry already resolved
    send_mac(50, 16'h0, 16'h0);         // R6 unknown id
    q_sweep();

    // release rules
    rel(1);                             // pending: ignored (R9)
    chk("R9 pending release ignored", data_ready, 0);
    rel(0);                             // verified: freed
    send_data(20);                      // takes tag 0
    rel(3); rel(2);
    send_data(21);                      // lowest free: tag 2
    send_data(11);                      // duplicate id, tag 3
    send_mac(11, 16'h5, 16'h5);         // R7: resolves tag 1
    q_sweep();
    send_mac(11, 16'h6, 16'h7);         // R7: now tag 3, violation
    q_sweep();

    // same-cycle collisions (R10)
    do_reset();
    send_data(1); send_data(2);
    send_mac(2, 16'h9, 16'h9);
    release_valid = 1; release_tag = 2'd1; data_valid = 1; data_id = 6'd4;
    @(negedge clk);
    release_valid = 0; data_valid = 0;
    chk("R10 released entry not reused same cycle", alloc_tag, 2);
    mst[1] = 0; mst[2] = 1; mid[2] = 4;
    data_valid = 1; data_id = 6'd6;
    mac_valid = 1; mac_id = 6'd6; mac_rx = 16'h1; mac_calc = 16'h1;
    @(negedge clk);
    data_valid = 0; mac_valid = 0;
    chk("R10 alloc in collision cycle", alloc_tag, 1);
    chk("R10 same-cycle MAC is orphan", orphan_err, 1);
    mst[1] = 1; mid[1] = 6;
    send_mac(6, 16'h1, 16'h1);
    q_sweep();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule